// File: doc/BRIEF.md
# CAN Transmit Driver Guard

This block is the digital control stage between a CAN protocol controller and the analog differential bus driver. On every clock it decides whether the driver may be active and whether it should drive a dominant level. It takes four inputs: transmit data, a silent-mode select, an overtemperature flag and a supply-undervoltage flag. All four are resynchronised into the local clock domain before any decision is made. The receive comparator result is inverted straight onto the receive data output and does not pass through any flop.

A stuck-dominant watchdog protects the shared bus. After transmit data falls, the block counts clock cycles while transmit stays low. If the count reaches `TOUT_CYC`, the driver is latched off until transmit data returns recessive. Silent mode and either fault flag also turn the driver off, each on its own terms. Three live (not sticky) status outputs report the timeout latch, the thermal lockout and the undervoltage lockout separately. The timeout is set in clock cycles and must be longer than eleven bit times at the slowest bit rate that will be used.

Top module: `can_drv_guard`

## Requirements
- R1: `rx_data_o` is the logical inverse of `rx_dom_i` (1 = comparator sees dominant) at all times, combinationally, in both modes and during any lockout.
- R2: `tx_data_i`, `mode_silent_i`, `ovt_flag_i` and `uvlo_flag_i` each pass through two flops. A change on one of them reaches the outputs after the second rising clock edge that follows the change, and not after the first.
- R3: In normal mode (`mode_silent_i` = 0), with no fault and no timeout, `drv_en_o` is 1 and `drv_dom_o` is the inverse of the synchronised transmit data (transmit 0 = dominant request). `drv_dom_o` is never 1 while `drv_en_o` is 0.
- R4: In silent mode (`mode_silent_i` = 1), `drv_en_o` and `drv_dom_o` are 0 whatever the transmit data is.
- R5: After a falling edge of synchronised transmit data in normal mode, the timeout latch sets at the edge that takes the `TOUT_CYC`-th consecutive low sample. From then on `stat_timeout_o` = 1 and `drv_en_o` = `drv_dom_o` = 0, so the driver produces a dominant level for at most `TOUT_CYC` cycles.
- R6: Once set, the timeout latch stays set while synchronised transmit data stays low. It clears at the first edge that samples transmit high, and driving then resumes with no other action.
- R7: A dominant request that ends after `TOUT_CYC`-1 low samples never sets the timeout.
- R8: Switching to silent mode clears the timeout latch and its counter. When the block returns to normal mode while transmit is still low, this counts as a fresh falling edge and a full new timeout period starts.
- R9: While the synchronised overtemperature flag is 1, `stat_therm_o` = 1 and the driver is off. Driving resumes on its own when the flag drops.
- R10: While the synchronised undervoltage flag is 1, `stat_uvlo_o` = 1 and the driver is off. Driving resumes on its own when the flag drops.
- R11: During reset and directly after it, `drv_en_o` = `drv_dom_o` = `stat_timeout_o` = 0. `stat_therm_o` and `stat_uvlo_o` read 1 until the fault inputs have been sampled through the synchroniser.
- R12: The timeout counter does not run in silent mode. Transmit held low for any time in silent mode never sets `stat_timeout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data_i | input | 1 | Transmit data from the protocol controller, 0 = dominant |
| mode_silent_i | input | 1 | 1 = silent (driver off), 0 = normal |
| ovt_flag_i | input | 1 | Overtemperature fault, 1 = hot |
| uvlo_flag_i | input | 1 | Supply undervoltage fault, 1 = low supply |
| rx_dom_i | input | 1 | Bus comparator result, 1 = dominant seen |
| rx_data_o | output | 1 | Receive data to the protocol controller, 0 = dominant |
| drv_en_o | output | 1 | Driver enable, 0 = outputs high impedance |
| drv_dom_o | output | 1 | Gated dominant request to the driver |
| stat_timeout_o | output | 1 | Live stuck-dominant timeout status |
| stat_therm_o | output | 1 | Live thermal lockout status |
| stat_uvlo_o | output | 1 | Live undervoltage lockout status |

## Verification
The bench attacks the exact edges of the timeout window. It holds transmit low for one sample fewer than the limit, then for exactly the limit. A counter that is off by one either cuts off a legal long frame or lets the driver stay dominant one cycle too long. It then holds transmit low through a timeout and beyond, checking that a latch which releases early, or one that needs more than a recessive level to clear, is caught. It also returns from silent mode with transmit still low, which exposes a design that carries stale timer state across a mode change or never re-arms because it saw no edge. The remaining cases are latency checks one cycle either side of the synchroniser delay, and faults that must release the driver without any transmit toggle.

// File: rtl/can_drv_guard_pkg.sv
// Package: can_drv_guard_pkg
// Shared types and constants for the CAN transmit driver guard.
// Assumes all control inputs are single-bit levels from another clock domain.
package can_drv_guard_pkg;

    // Bundle of the control inputs as seen by the synchroniser.
    typedef struct packed {
        logic tx_rec;   // 1 = recessive requested
        logic silent;   // 1 = silent mode
        logic ovt;      // 1 = overtemperature
        logic uvlo;     // 1 = supply undervoltage
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Safe state loaded by reset: recessive, normal mode, both faults assumed present.
    localparam ctl_t CTL_SAFE = '{tx_rec: 1'b1, silent: 1'b0, ovt: 1'b1, uvlo: 1'b1};

endpackage

// File: rtl/cg_sync.sv
// Module: cg_sync
// Multi-bit level synchroniser, STAGES flops deep per bit.
// Assumes each bit is an independent level; no bus coherency is implied.
module cg_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= d_i;
                end
            end else begin : g_next
                // Move the value one stage further along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/cg_dom_timer.sv
// Module: cg_dom_timer
// Stuck-dominant watchdog. It arms on a falling edge of synchronised transmit data
// in normal mode, counts low samples, and latches a timeout after TOUT_CYC of them.
// Recessive transmit or silent mode clears everything. Leaving silent mode counts as
// a recessive history, so transmit that is already low re-arms the timer.
// Assumes TOUT_CYC >= 2 and inputs already synchronous.
module cg_dom_timer #(
    parameter int TOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_rec_i,
    input  logic silent_i,
    output logic tout_o
);

    localparam int CW = $clog2(TOUT_CYC + 1);
    localparam logic [CW-1:0] LAST_BEFORE = CW'(TOUT_CYC - 1);

    logic          prev_rec_q;
    logic          armed_q;
    logic [CW-1:0] run_q;
    logic          tout_q;
    logic          clear;
    logic          fall;

    assign clear = silent_i | tx_rec_i;
    assign fall  = prev_rec_q & ~clear;

    // Remember whether the previous sample counted as recessive (edge history).
    always_ff @(posedge clk) begin
        if (!rst_n) prev_rec_q <= 1'b1;
        else        prev_rec_q <= clear;
    end

    // Arm, count and latch the dominant timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            run_q   <= '0;
            tout_q  <= 1'b0;
        end else if (clear) begin
            armed_q <= 1'b0;
            run_q   <= '0;
            tout_q  <= 1'b0;
        end else if (fall) begin
            armed_q <= 1'b1;
            run_q   <= CW'(1);
        end else if (armed_q && !tout_q) begin
            run_q <= run_q + CW'(1);
            if (run_q == LAST_BEFORE) tout_q <= 1'b1;
        end
    end

    assign tout_o = tout_q;

endmodule

// File: rtl/cg_drv_gate.sv
// Module: cg_drv_gate
// Combines mode, faults and the timeout latch into the driver enable and the gated
// dominant request. Purely combinational; all inputs come from flops.
module cg_drv_gate
    import can_drv_guard_pkg::*;
(
    input  ctl_t ctl_i,
    input  logic tout_i,
    output logic drv_en_o,
    output logic drv_dom_o
);

    logic blocked;

    // Any single reason is enough to keep the driver off.
    always_comb begin
        blocked   = ctl_i.silent | ctl_i.ovt | ctl_i.uvlo | tout_i;
        drv_en_o  = ~blocked;
        drv_dom_o = ~blocked & ~ctl_i.tx_rec;
    end

endmodule

// File: rtl/can_drv_guard.sv
// Module: can_drv_guard
// Top of the CAN transmit driver guard: synchronises the control inputs, runs the
// stuck-dominant watchdog, gates the driver and reports live status.
// Receive data is a combinational inversion of the comparator output.
// Assumes a synchronous active-low reset and TOUT_CYC >= 2.
module can_drv_guard
    import can_drv_guard_pkg::*;
#(
    parameter int TOUT_CYC    = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_data_i,
    input  logic mode_silent_i,
    input  logic ovt_flag_i,
    input  logic uvlo_flag_i,
    input  logic rx_dom_i,
    output logic rx_data_o,
    output logic drv_en_o,
    output logic drv_dom_o,
    output logic stat_timeout_o,
    output logic stat_therm_o,
    output logic stat_uvlo_o
);

    ctl_t             ctl_raw;
    ctl_t             ctl_s;
    logic [CTL_W-1:0] ctl_s_vec;
    logic             tout;
    logic             tx_rec_s;
    logic             silent_s;

    // Bundle the raw control inputs.
    always_comb begin
        ctl_raw.tx_rec = tx_data_i;
        ctl_raw.silent = mode_silent_i;
        ctl_raw.ovt    = ovt_flag_i;
        ctl_raw.uvlo   = uvlo_flag_i;
    end

    cg_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_SAFE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ctl_raw),
        .q_o   (ctl_s_vec)
    );

    assign ctl_s    = ctl_t'(ctl_s_vec);
    assign tx_rec_s = ctl_s.tx_rec;
    assign silent_s = ctl_s.silent;

    cg_dom_timer #(
        .TOUT_CYC (TOUT_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_rec_i (tx_rec_s),
        .silent_i (silent_s),
        .tout_o   (tout)
    );

    cg_drv_gate u_gate (
        .ctl_i     (ctl_s),
        .tout_i    (tout),
        .drv_en_o  (drv_en_o),
        .drv_dom_o (drv_dom_o)
    );

    // Receive path and live status.
    assign rx_data_o      = ~rx_dom_i;
    assign stat_timeout_o = tout;
    assign stat_therm_o   = ctl_s.ovt;
    assign stat_uvlo_o    = ctl_s.uvlo;

endmodule

// File: rtl/can_drv_guard_chk.sv
// Module: can_drv_guard_chk
// Property checker bound into can_drv_guard. A counter bounds the dominant run
// length, so no property needs a parameter-sized delay.
module can_drv_guard_chk #(
    parameter int TOUT_CYC = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic tx_sync,
    input logic silent_sync,
    input logic rx_dom_i,
    input logic rx_data_o,
    input logic drv_en_o,
    input logic drv_dom_o,
    input logic stat_timeout_o,
    input logic stat_therm_o,
    input logic stat_uvlo_o
);

    int unsigned dom_run;

    // Count consecutive cycles with a dominant drive request.
    always_ff @(posedge clk) begin
        if (!rst_n)         dom_run <= 0;
        else if (drv_dom_o) dom_run <= dom_run + 1;
        else                dom_run <= 0;
    end

    AST_RX_INVERT:   assert property (@(posedge clk) disable iff (!rst_n) rx_data_o == !rx_dom_i); // R1
    AST_DOM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) drv_dom_o |-> drv_en_o); // R3
    AST_SILENT_OFF:  assert property (@(posedge clk) disable iff (!rst_n) silent_sync |-> !drv_en_o); // R4
    AST_TOUT_OFF:    assert property (@(posedge clk) disable iff (!rst_n) stat_timeout_o |-> !drv_en_o); // R5
    AST_DOM_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) drv_dom_o |-> dom_run < TOUT_CYC); // R5
    AST_TOUT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) stat_timeout_o && !tx_sync && !silent_sync |=> stat_timeout_o); // R6
    AST_TOUT_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n) tx_sync |=> !stat_timeout_o); // R6
    AST_SILENT_CLR:  assert property (@(posedge clk) disable iff (!rst_n) silent_sync |=> !stat_timeout_o); // R8
    AST_THERM_OFF:   assert property (@(posedge clk) disable iff (!rst_n) stat_therm_o |-> !drv_en_o); // R9
    AST_UVLO_OFF:    assert property (@(posedge clk) disable iff (!rst_n) stat_uvlo_o |-> !drv_en_o); // R10

endmodule

bind can_drv_guard can_drv_guard_chk #(.TOUT_CYC(TOUT_CYC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_sync        (tx_rec_s),
    .silent_sync    (silent_s),
    .rx_dom_i       (rx_dom_i),
    .rx_data_o      (rx_data_o),
    .drv_en_o       (drv_en_o),
    .drv_dom_o      (drv_dom_o),
    .stat_timeout_o (stat_timeout_o),
    .stat_therm_o   (stat_therm_o),
    .stat_uvlo_o    (stat_uvlo_o)
);

// File: tb/can_drv_guard_bench.sv
`timescale 1ns/1ps
module can_drv_guard_bench;

    localparam int TOUT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx = 1'b1, sil = 1'b0, ovt = 1'b0, uvlo = 1'b0, rx_dom = 1'b0;
    logic rx_data_o, drv_en_o, drv_dom_o, stat_timeout_o, stat_therm_o, stat_uvlo_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    can_drv_guard #(.TOUT_CYC(TOUT), .SYNC_STAGES(2)) u_can_drv_guard (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_data_i      (tx),
        .mode_silent_i  (sil),
        .ovt_flag_i     (ovt),
        .uvlo_flag_i    (uvlo),
        .rx_dom_i       (rx_dom),
        .rx_data_o      (rx_data_o),
        .drv_en_o       (drv_en_o),
        .drv_dom_o      (drv_dom_o),
        .stat_timeout_o (stat_timeout_o),
        .stat_therm_o   (stat_therm_o),
        .stat_uvlo_o    (stat_uvlo_o)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    // Inputs as seen through a two-cycle delay: {tx, sil, ovt, uvlo}.
    bit [3:0] dly[$];
    bit [3:0] old_in, cur;
    int  low_run = 0;
    bit  armed = 0, was_rec = 1, m_tout = 0, started = 0;
    bit  e_en;

    always @(posedge clk) begin
        if (!rst_n) begin
            dly = '{4'b1011, 4'b1011};
            low_run = 0; armed = 0; was_rec = 1; m_tout = 0; started = 1;
        end else begin
            old_in = dly[0];
            if (old_in[3] || old_in[2]) begin
                low_run = 0; armed = 0;
            end else if (was_rec) begin
                armed = 1; low_run = 1;
            end else if (armed) begin
                low_run++;
            end
            was_rec = old_in[3] || old_in[2];
            m_tout  = armed && (low_run >= TOUT);
            void'(dly.pop_front());
            dly.push_back({tx, sil, ovt, uvlo});
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            cur  = dly[0];
            e_en = !cur[2] && !m_tout && !cur[1] && !cur[0];
            chk("R3 model drv_en", drv_en_o, e_en);
            chk("R3 model drv_dom", drv_dom_o, e_en && !cur[3]);
            chk("R5 model timeout", stat_timeout_o, m_tout);
            chk("R9 model therm", stat_therm_o, cur[1]);
            chk("R10 model uvlo", stat_uvlo_o, cur[0]);
            chk("R1 model rx", rx_data_o, !rx_dom);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // ---------------- directed stimulus ----------------
    initial begin
        @(posedge clk); #1;
        tick(3);
        // R11 reset state
        chk("R11 drv_en in reset", drv_en_o, 1'b0);
        chk("R11 drv_dom in reset", drv_dom_o, 1'b0);
        chk("R11 timeout in reset", stat_timeout_o, 1'b0);
        chk("R11 therm in reset", stat_therm_o, 1'b1);
        chk("R11 uvlo in reset", stat_uvlo_o, 1'b1);
        rst_n = 1'b1;
        tick(1);
        chk("R2 therm one edge after reset", stat_therm_o, 1'b1);
        tick(1);
        chk("R2 therm two edges after reset", stat_therm_o, 1'b0);
        chk("R3 enabled idle", drv_en_o, 1'b1);

        // R1 receive inversion
        rx_dom = 1'b1; #1;
        chk("R1 rx dominant", rx_data_o, 1'b0);
        rx_dom = 1'b0; #1;
        chk("R1 rx recessive", rx_data_o, 1'b1);

        // R2 / R3 latency of a dominant request
        tick(1);
        tx = 1'b0;
        tick(1);
        chk("R2 dom not after one edge", drv_dom_o, 1'b0);
        tick(1);
        chk("R3 dom after two edges", drv_dom_o, 1'b1);
        tx = 1'b1;
        tick(2);
        chk("R3 dom released", drv_dom_o, 1'b0);
        tick(2);

        // R7 one sample short of the limit
        tx = 1'b0;
        tick(TOUT - 1);
        tx = 1'b1;
        tick(3);
        chk("R7 no timeout at limit-1", stat_timeout_o, 1'b0);
        chk("R7 still enabled", drv_en_o, 1'b1);
        tick(2);

        // R5 exact timeout edge
        tx = 1'b0;
        tick(TOUT + 1);
        chk("R5 timeout not yet", stat_timeout_o, 1'b0);
        chk("R5 still dominant", drv_dom_o, 1'b1);
        tick(1);
        chk("R5 timeout set", stat_timeout_o, 1'b1);
        chk("R5 driver off", drv_en_o, 1'b0);
        chk("R5 dominant off", drv_dom_o, 1'b0);

        // R6 hold and clear
        tick(20);
        chk("R6 latch holds", stat_timeout_o, 1'b1);
        tx = 1'b1;
        tick(2);
        chk("R6 latch until sampled high", stat_timeout_o, 1'b1);
        tick(1);
        chk("R6 latch cleared", stat_timeout_o, 1'b0);
        chk("R6 driver back", drv_en_o, 1'b1);
        tick(2);

        // R8 silent clears, return re-arms
        tx = 1'b0;
        tick(TOUT + 5);
        chk("R8 timed out before silent", stat_timeout_o, 1'b1);
        sil = 1'b1;
        tick(3);
        chk("R8 silent cleared timeout", stat_timeout_o, 1'b0);
        chk("R4 silent driver off", drv_en_o, 1'b0);
        sil = 1'b0;
        tick(2);
        chk("R8 dominant after return", drv_dom_o, 1'b1);
        chk("R8 no stale timeout", stat_timeout_o, 1'b0);
        tick(TOUT - 1);
        chk("R8 fresh period not expired", stat_timeout_o, 1'b0);
        tick(1);
        chk("R8 fresh period expired", stat_timeout_o, 1'b1);
        tx = 1'b1;
        tick(3);

        // R12 / R4 silent with long dominant request
        sil = 1'b1;
        tick(3);
        tx = 1'b0;
        tick(3 * TOUT);
        chk("R12 no timeout in silent", stat_timeout_o, 1'b0);
        chk("R4 silent no enable", drv_en_o, 1'b0);
        chk("R4 silent no dominant", drv_dom_o, 1'b0);
        rx_dom = 1'b1; #1;
        chk("R1 rx in silent", rx_data_o, 1'b0);
        rx_dom = 1'b0;
        tx = 1'b1;
        sil = 1'b0;
        tick(3);

        // R9 thermal lockout and automatic resume
        ovt = 1'b1;
        tick(2);
        chk("R9 therm status", stat_therm_o, 1'b1);
        chk("R9 driver off", drv_en_o, 1'b0);
        tx = 1'b0;
        tick(3);
        chk("R9 no dominant while hot", drv_dom_o, 1'b0);
        tx = 1'b1;
        tick(2);
        ovt = 1'b0;
        tick(2);
        chk("R9 auto resume", drv_en_o, 1'b1);

        // R10 undervoltage lockout and resume
        uvlo = 1'b1;
        tx = 1'b0;
        tick(2);
        chk("R10 uvlo status", stat_uvlo_o, 1'b1);
        chk("R10 no dominant", drv_dom_o, 1'b0);
        uvlo = 1'b0;
        tick(2);
        chk("R10 dominant after resume", drv_dom_o, 1'b1);
        tx = 1'b1;
        tick(3);

        // Mixed random traffic, checked cycle by cycle against the model
        for (int ph = 0; ph < 6; ph++) begin
            for (int i = 0; i < 2000; i++) begin
                int rate;
                rate = (ph % 2 == 0) ? 6 : 70;
                if ($urandom % rate == 0)  tx = ~tx;
                if ($urandom % 400 == 0)   sil = ~sil;
                ovt    = ($urandom % 300 == 0) ? ~ovt : ovt;
                uvlo   = ($urandom % 350 == 0) ? ~uvlo : uvlo;
                rx_dom = $urandom % 2;
                tick(1);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule